// File: doc/BRIEF.md
# Memory Scan Port Controller

This block is the serial test port of a memory die. A four-bit state sequencer follows the test mode line on every rising test clock edge. The block holds a three-bit operation register and three data chains: a one-bit pass-through stage, a 32-bit identity word, and a boundary chain whose length is a parameter. The current operation decides which chain lies between the serial input and the serial output. It also decides whether the memory's data drivers are forced to high impedance and whether the boundary update register drives the pins.

There is no separate asynchronous test reset pin. The port returns to its reset state through the power-on reset input or through five rising edges with the mode line held high. The serial stream has no back-pressure and no valid/ready pair, because the test clock alone paces it. The data input is taken on the rising edge, and the data output only changes on the falling edge.

Top module: `mem_scan_port`

## Requirements
- R1: While `por_n` is low, `tap_state` is 0 (reset), `tdo_oe`, `mem_out_hiz` and `bnd_drive_en` are 0, and `bnd_drive_val` is all zeros.
- R2: Five consecutive rising edges with `tms` high bring `tap_state` to 0 from any state. From data-shift, four such edges leave it at 9.
- R3: `tap_state` follows the standard sixteen-state sequence on each rising edge of `tck`. The codes are: 0 reset, 1 idle, 2 select-data, 3 capture-data, 4 shift-data, 5 exit1-data, 6 pause-data, 7 exit2-data, 8 update-data, 9 select-op, 10 capture-op, 11 shift-op, 12 exit1-op, 13 pause-op, 14 exit2-op, 15 update-op.
- R4: Capture in the operation path loads binary 001, which is shifted out least significant bit first. A newly shifted operation has no effect on any output until the update-op edge.
- R5: With operation 001, capture-data loads a 32-bit word that is shifted out LSB first. The layout is: bit 0 = 1, bits 11:1 vendor (default 0x0D5), bits 28:12 type (default 0x0A5C3), bits 31:29 revision (default 2).
- R6: Operation 111, and the unused codes 011, 101 and 110, select a one-bit stage that captures 0. Each `tdi` bit reappears on `tdo` one shift later.
- R7: With operation 100, capture-data loads `pad_in` into the boundary chain, which is shifted LSB first.
- R8: With operation 010, `mem_out_hiz` is 1, `bnd_drive_en` is 0, and the boundary chain is in the scan path.
- R9: Update-data under any boundary operation (000, 010, 100) copies the shifted chain into `bnd_drive_val`. With operation 000, `bnd_drive_en` is 1 from the update-op edge onward, and the value driven is the preloaded one.
- R10: `tdo_oe` is 1 only in shift-op and shift-data. `tdo` changes only while `tck` is low.
- R11: The reset state makes 001 the active operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Test mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| pad_in | input | BSR_W | Pin values seen by the boundary chain at capture |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| tap_state | output | 4 | Current sequencer state code |
| mem_out_hiz | output | 1 | Forces memory data outputs to high impedance |
| bnd_drive_en | output | 1 | Pins driven from the boundary update register |
| bnd_drive_val | output | BSR_W | Boundary update register contents |

## Verification
Two functions meet on one rising edge: the update-op edge that makes the external-drive operation active, and the boundary update register that was filled by an earlier preload. The bench preloads a pattern under the sample operation, then shifts in the external-drive code. Just before that edge, in pause-op, it checks that nothing is driven yet. Right after the edge, it checks that drive is enabled and that the preloaded pattern, not a reset or stale value, appears on `bnd_drive_val`.

// File: rtl/scanport_pkg.sv
package scanport_pkg;

  typedef enum logic [3:0] {
    ST_RESET    = 4'd0,
    ST_IDLE     = 4'd1,
    ST_DR_SEL   = 4'd2,
    ST_DR_CAP   = 4'd3,
    ST_DR_SHIFT = 4'd4,
    ST_DR_EXIT1 = 4'd5,
    ST_DR_PAUSE = 4'd6,
    ST_DR_EXIT2 = 4'd7,
    ST_DR_UPD   = 4'd8,
    ST_IR_SEL   = 4'd9,
    ST_IR_CAP   = 4'd10,
    ST_IR_SHIFT = 4'd11,
    ST_IR_EXIT1 = 4'd12,
    ST_IR_PAUSE = 4'd13,
    ST_IR_EXIT2 = 4'd14,
    ST_IR_UPD   = 4'd15
  } tap_state_e;

  typedef enum logic [1:0] {
    CH_BYPASS   = 2'd0,
    CH_ID       = 2'd1,
    CH_BOUNDARY = 2'd2
  } chain_e;

  localparam int OP_W        = 3;
  localparam int ID_W        = 32;
  localparam int ID_REV_W    = 3;
  localparam int ID_PART_W   = 17;
  localparam int ID_VENDOR_W = 11;

  localparam logic [OP_W-1:0] OP_EXTEST     = 3'b000;
  localparam logic [OP_W-1:0] OP_IDCODE     = 3'b001;
  localparam logic [OP_W-1:0] OP_HIZ_SAMPLE = 3'b010;
  localparam logic [OP_W-1:0] OP_SAMPLE     = 3'b100;
  localparam logic [OP_W-1:0] OP_BYPASS     = 3'b111;

  localparam logic [OP_W-1:0] CAPTURE_PATTERN = 3'b001;

endpackage

// File: rtl/tap_seq.sv
module tap_seq
  import scanport_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    case (state)
      ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
      default:     nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state <= ST_RESET;
    else        state <= nxt;
  end

  // Run length of consecutive high mode samples, saturating at five.
  logic [2:0] high_run;
  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)                high_run <= 3'd0;
    else if (!tms)             high_run <= 3'd0;
    else if (high_run != 3'd5) high_run <= high_run + 3'd1;
  end

  a_r2_five_high_resets: assert property (@(posedge tck) disable iff (!por_n)
    (high_run == 3'd5) |-> (state == ST_RESET));

  a_r3_capture_leaves: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_DR_CAP) |=> (state == ST_DR_SHIFT || state == ST_DR_EXIT1));

endmodule

// File: rtl/tap_opreg.sv
module tap_opreg
  import scanport_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [OP_W-1:0] op,
  output logic            stage_lsb
);

  logic [OP_W-1:0] stage;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      stage <= CAPTURE_PATTERN;
      op    <= OP_IDCODE;
    end else begin
      case (state)
        ST_IR_CAP:   stage <= CAPTURE_PATTERN;
        ST_IR_SHIFT: stage <= {tdi, stage[OP_W-1:1]};
        default:     stage <= stage;
      endcase
      if (state == ST_RESET)       op <= OP_IDCODE;
      else if (state == ST_IR_UPD) op <= stage;
    end
  end

  assign stage_lsb = stage[0];

  a_r11_reset_loads_id: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_RESET) |=> (op == OP_IDCODE));

  a_r4_op_held_until_update: assert property (@(posedge tck) disable iff (!por_n)
    (state != ST_IR_UPD && state != ST_RESET) |=> $stable(op));

endmodule

// File: rtl/tap_opdec.sv
module tap_opdec
  import scanport_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output chain_e          chain,
  output logic            drive_en,
  output logic            hiz
);

  always_comb begin
    chain    = CH_BYPASS;
    drive_en = 1'b0;
    hiz      = 1'b0;
    case (op)
      OP_EXTEST: begin
        chain    = CH_BOUNDARY;
        drive_en = 1'b1;
      end
      OP_IDCODE:     chain = CH_ID;
      OP_HIZ_SAMPLE: begin
        chain = CH_BOUNDARY;
        hiz   = 1'b1;
      end
      OP_SAMPLE:     chain = CH_BOUNDARY;
      default:       chain = CH_BYPASS;
    endcase
  end

endmodule

// File: rtl/tap_datachains.sv
module tap_datachains
  import scanport_pkg::*;
#(
  parameter int              BSR_W  = 16,
  parameter logic [ID_W-1:0] ID_VAL = 32'h1
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tdi,
  input  tap_state_e       state,
  input  chain_e           chain,
  input  logic [BSR_W-1:0] pad_in,
  output logic [BSR_W-1:0] pad_out,
  output logic             chain_lsb
);

  logic             byp;
  logic [ID_W-1:0]  id_sh;
  logic [BSR_W-1:0] bsr_sh;
  logic [BSR_W-1:0] bsr_next;

  generate
    if (BSR_W == 1) begin : g_bsr_single
      assign bsr_next = tdi;
    end else begin : g_bsr_multi
      assign bsr_next = {tdi, bsr_sh[BSR_W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      byp     <= 1'b0;
      id_sh   <= '0;
      bsr_sh  <= '0;
      pad_out <= '0;
    end else begin
      case (state)
        ST_DR_CAP: begin
          case (chain)
            CH_ID:       id_sh  <= ID_VAL;
            CH_BOUNDARY: bsr_sh <= pad_in;
            default:     byp    <= 1'b0;
          endcase
        end
        ST_DR_SHIFT: begin
          case (chain)
            CH_ID:       id_sh  <= {tdi, id_sh[ID_W-1:1]};
            CH_BOUNDARY: bsr_sh <= bsr_next;
            default:     byp    <= tdi;
          endcase
        end
        ST_DR_UPD: begin
          if (chain == CH_BOUNDARY) pad_out <= bsr_sh;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (chain)
      CH_ID:       chain_lsb = id_sh[0];
      CH_BOUNDARY: chain_lsb = bsr_sh[0];
      default:     chain_lsb = byp;
    endcase
  end

  a_r6_bypass_captures_zero: assert property (@(posedge tck) disable iff (!por_n)
    (state == ST_DR_CAP && chain == CH_BYPASS) |=> (byp == 1'b0));

  a_r9_update_only_changes_pins: assert property (@(posedge tck) disable iff (!por_n)
    (state != ST_DR_UPD) |=> $stable(pad_out));

endmodule

// File: rtl/mem_scan_port.sv
module mem_scan_port
  import scanport_pkg::*;
#(
  parameter int                     BSR_W     = 16,
  parameter logic [ID_REV_W-1:0]    ID_REV    = 3'd2,
  parameter logic [ID_PART_W-1:0]   ID_PART   = 17'h0A5C3,
  parameter logic [ID_VENDOR_W-1:0] ID_VENDOR = 11'h0D5
) (
  input  logic             tck,
  input  logic             por_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [BSR_W-1:0] pad_in,
  output logic             tdo,
  output logic             tdo_oe,
  output logic [3:0]       tap_state,
  output logic             mem_out_hiz,
  output logic             bnd_drive_en,
  output logic [BSR_W-1:0] bnd_drive_val
);

  localparam logic [ID_W-1:0] ID_VAL = {ID_REV, ID_PART, ID_VENDOR, 1'b1};

  tap_state_e      st;
  logic [OP_W-1:0] op;
  logic            op_lsb;
  logic            dr_lsb;
  chain_e          chain;

  tap_seq u_seq (
    .tck   (tck),
    .por_n (por_n),
    .tms   (tms),
    .state (st)
  );

  tap_opreg u_opreg (
    .tck       (tck),
    .por_n     (por_n),
    .tdi       (tdi),
    .state     (st),
    .op        (op),
    .stage_lsb (op_lsb)
  );

  tap_opdec u_dec (
    .op       (op),
    .chain    (chain),
    .drive_en (bnd_drive_en),
    .hiz      (mem_out_hiz)
  );

  tap_datachains #(
    .BSR_W  (BSR_W),
    .ID_VAL (ID_VAL)
  ) u_chains (
    .tck       (tck),
    .por_n     (por_n),
    .tdi       (tdi),
    .state     (st),
    .chain     (chain),
    .pad_in    (pad_in),
    .pad_out   (bnd_drive_val),
    .chain_lsb (dr_lsb)
  );

  // Serial output is retimed to the falling edge.
  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (st == ST_IR_SHIFT) ? op_lsb : dr_lsb;
      tdo_oe <= (st == ST_IR_SHIFT) || (st == ST_DR_SHIFT);
    end
  end

  assign tap_state = st;

  a_r10_drive_only_in_shift: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe |-> (st == ST_IR_SHIFT || st == ST_DR_SHIFT));

  a_r8_hiz_excludes_drive: assert property (@(posedge tck) disable iff (!por_n)
    mem_out_hiz |-> (!bnd_drive_en && op == OP_HIZ_SAMPLE));

endmodule

// File: tb/tb_mem_scan_port.sv
module tb_mem_scan_port;

  localparam int BW = 16;
  localparam logic [31:0] ID_EXP = {3'd2, 17'h0A5C3, 11'h0D5, 1'b1};

  logic          tck = 1'b0;
  logic          por_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic [BW-1:0] pad_in = '0;
  logic          tdo, tdo_oe, mem_out_hiz, bnd_drive_en;
  logic [3:0]    tap_state;
  logic [BW-1:0] bnd_drive_val;

  mem_scan_port dut (
    .tck           (tck),
    .por_n         (por_n),
    .tms           (tms),
    .tdi           (tdi),
    .pad_in        (pad_in),
    .tdo           (tdo),
    .tdo_oe        (tdo_oe),
    .tap_state     (tap_state),
    .mem_out_hiz   (mem_out_hiz),
    .bnd_drive_en  (bnd_drive_en),
    .bnd_drive_val (bnd_drive_val)
  );

  always #2 tck = ~tck;

  int    n_run = 0;
  int    n_fail = 0;
  int    edge_viol = 0;
  bit    mon_en = 1'b0;
  bit    exp_q[$];
  string tag_q[$];

  int walk_tms[44] = '{1,0,0,1,0,0,0,1,0,0, 1,0,1,1,0,1,0,1,0,1,
                       1,1,1,0,0,0,1,0,0,1, 0,1,1,0,1,1,0,1,0,1,
                       1,1,1,1};
  int walk_st[44]  = '{0,1,1,2,3,4,4,5,6,6, 7,4,5,8,1,2,3,5,6,7,
                       8,2,9,10,11,11,12,13,13,14, 11,12,15,1,2,9,10,12,13,14,
                       15,2,9,0};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected serial bit per driven shift edge.
  always @(posedge tck) begin
    if (mon_en && tdo_oe === 1'b1) begin
      if (exp_q.size() == 0) begin
        n_run++;
        n_fail++;
        $display("FAIL R10 unexpected drive: actual oe 1 expected 0");
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {63'd0, tdo}, {63'd0, e});
      end
    end
  end

  always @(tdo) if (por_n === 1'b1 && tck === 1'b1) edge_viol++;

  task automatic tick(input bit m, input bit d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic to_reset();
    for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
  endtask

  // From idle: shift a new operation; R4 checks capture pattern and deferred effect.
  task automatic load_ir(input logic [2:0] code);
    logic hiz0, en0;
    hiz0 = mem_out_hiz;
    en0  = bnd_drive_en;
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      exp_q.push_back(i == 0);
      tag_q.push_back("R4 capture pattern");
      tick(i == 2, code[i]);
    end
    tick(1'b0, 1'b0);
    chk("R4 pause state", tap_state, 13);
    chk("R4 hiz not yet changed", mem_out_hiz, hiz0);
    chk("R4 drive not yet changed", bnd_drive_en, en0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
  endtask

  // Driver: from idle, scan n bits through the data path, queueing expected output.
  task automatic scan_dr(input int n, input logic [63:0] din, input logic [63:0] exp,
                         input string tag);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp[i]);
      tag_q.push_back(tag);
      tick(i == n - 1, din[i]);
    end
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R10 all shifted bits seen", exp_q.size(), 0);
  endtask

  initial begin
    #(4 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [2:0] rsv[3];
    rsv = '{3'b011, 3'b101, 3'b110};

    repeat (3) @(posedge tck);
    #1;
    chk("R1 state", tap_state, 0);
    chk("R1 tdo_oe", tdo_oe, 0);
    chk("R1 hiz", mem_out_hiz, 0);
    chk("R1 drive_en", bnd_drive_en, 0);
    chk("R1 drive_val", bnd_drive_val, 0);
    @(negedge tck);
    por_n = 1'b1;

    // R3: every arc of the state graph
    for (int i = 0; i < 44; i++) begin
      tick(walk_tms[i] != 0, 1'b0);
      chk($sformatf("R3 walk step %0d", i), tap_state, walk_st[i]);
    end

    // R2: reset through five high samples
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R2 reached shift-data", tap_state, 4);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0);
    chk("R2 four highs not reset", tap_state, 9);
    tick(1'b1, 1'b0);
    chk("R2 fifth high resets", tap_state, 0);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R2 reached pause-op", tap_state, 13);
    to_reset();
    chk("R2 reset from pause-op", tap_state, 0);

    tick(1'b0, 1'b0);
    chk("R10 idle no drive", tdo_oe, 0);
    mon_en = 1'b1;

    scan_dr(32, 64'd0, {32'd0, ID_EXP}, "R5 id word");

    load_ir(3'b111);
    scan_dr(8, 64'hA5, 64'h4A, "R6 bypass delay");
    foreach (rsv[k]) begin
      load_ir(rsv[k]);
      scan_dr(8, 64'h3C, 64'h78, "R6 unused code as bypass");
    end

    to_reset();
    tick(1'b0, 1'b0);
    scan_dr(32, 64'd0, {32'd0, ID_EXP}, "R11 id after reset");

    pad_in = 16'hB36E;
    load_ir(3'b100);
    scan_dr(16, 64'h5AC1, 64'hB36E, "R7 sample capture");
    chk("R9 preload value", bnd_drive_val, 16'h5AC1);
    chk("R9 no drive under sample", bnd_drive_en, 0);

    load_ir(3'b000);
    chk("R9 drive from update-op", bnd_drive_en, 1);
    chk("R9 preloaded value driven", bnd_drive_val, 16'h5AC1);
    pad_in = 16'h0F0F;
    scan_dr(16, 64'hC3A5, 64'h0F0F, "R9 capture under drive");
    chk("R9 new value driven", bnd_drive_val, 16'hC3A5);

    load_ir(3'b010);
    chk("R8 hiz on", mem_out_hiz, 1);
    chk("R8 drive off", bnd_drive_en, 0);
    pad_in = 16'h7E81;
    scan_dr(16, 64'h1234, 64'h7E81, "R8 boundary in path");

    to_reset();
    chk("R11 hiz cleared by reset", mem_out_hiz, 0);
    chk("R11 drive off after reset", bnd_drive_en, 0);
    chk("R10 no drive in reset", tdo_oe, 0);
    chk("R10 tdo only moves with tck low", edge_viol, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule